// File: doc/BRIEF.md
# Iterative Feistel Block Cipher Core

This core encrypts or decrypts a single 64-bit block through a 16-round Feistel network. Only one round datapath exists. A feedback register holds the two 32-bit halves between rounds. The round function uses four key-dependent 256-entry substitution tables and an 18-entry subkey array. All of these sit in internal synchronous RAMs.

A key-setup controller fills the tables through a write port. It then pulses `start` with a block and a direction. The core raises `busy`, steps through the rounds at two cycles per round, and then applies the final whitening. It presents the result on `dout` with a one-cycle `done` pulse. Decryption uses the same datapath and walks the subkey array from the last entry down to the first.

Top module: `feistel_block_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `busy` and `done` are 0 and `dout` is all zeros.
- R2: Encryption uses left half L = din[63:32] and right half R = din[31:0]. Each of the 16 rounds, with i counting 0..15, does L ^= K[i], then R ^= F(L), then swaps the halves. After the last round the swap is undone, then R ^= K[16] and L ^= K[17], and dout = {L, R}. Here F(x) = ((T0[x[31:24]] + T1[x[23:16]]) ^ T2[x[15:8]]) + T3[x[7:0]], with both additions taken modulo 2^32.
- R3: When `decrypt` is 1 at start, the same procedure is applied with subkeys K[17] down to K[0], so K[17-i] is used in round i and the whitening uses K[1] on R and K[0] on L. Decrypting an encrypted block returns the original block.
- R4: `done` rises exactly 35 clock edges after the edge that accepts `start` (2 per round plus 3). `busy` is high from the edge after acceptance until the edge at which `done` rises.
- R5: `done` is high for exactly one cycle. `dout` changes only in a cycle where `done` is high and holds its value otherwise.
- R6: A `start` pulse while `busy` is high is ignored. The block in flight completes with its original data and direction.
- R7: While `busy` is low, a write with `wr_en` = 1 stores `wr_data` at entry `wr_addr`. `wr_sel` values 0..3 select table T0..T3, and 4 selects the subkey array K. The new value takes effect from the next block.
- R8: Writes presented while `busy` is high are discarded and leave every table and subkey unchanged.
- R9: Subkey writes with `wr_addr` of 18 or above are discarded, even when the low address bits would alias a valid entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a block when idle |
| decrypt | input | 1 | Direction at start: 0 encrypt, 1 decrypt |
| din | input | 64 | Input block, left half in the upper 32 bits |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle pulse: dout is valid |
| dout | output | 64 | Result block, held until the next result |
| wr_en | input | 1 | Table/subkey write strobe |
| wr_sel | input | 3 | 0..3 table T0..T3, 4 subkey array |
| wr_addr | input | 8 | Entry index |
| wr_data | input | 32 | Entry value |

## Verification
Four sets of blocks are driven: all-zero, all-ones, a single set bit walked across all 64 positions, and a sweep of all 256 values in each byte of the left half. The single-bit walk catches half-swap and whitening-order errors. The byte sweeps separate the four table lookups from each other and from the add/XOR order in F. Each block is also decrypted, checked against an arithmetic model, and round-tripped, which exposes reversed subkey indexing. Targeted cases aim a first-round lookup at one known table entry and then write it during and outside a run. Further cases inject an aliasing subkey address and a mid-run `start`, so that discarded and accepted writes give different results.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int NUM_TBL = 4;
  localparam logic [2:0] SEL_SUBKEY = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIME,
    ST_RND_A,
    ST_RND_B,
    ST_WHIT1,
    ST_WHIT2
  } fc_state_e;
endpackage

// File: rtl/fc_sync_ram.sv
module fc_sync_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fc_round_fn.sv
module fc_round_fn
  import fc_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic [NUM_TBL-1:0][HALF_W-1:0] s_word,
  output logic [HALF_W-1:0]              f_out
);
  logic [HALF_W-1:0] sum01, mix2;

  always_comb begin
    sum01 = s_word[0] + s_word[1];
    mix2  = sum01 ^ s_word[2];
    f_out = mix2 + s_word[3];
  end
endmodule

// File: rtl/fc_round_ctrl.sv
module fc_round_ctrl
  import fc_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int ROUNDS = 16,
  parameter int TBL_AW = 8,
  localparam int NKEYS = ROUNDS + 2,
  localparam int SK_AW = $clog2(NKEYS),
  localparam int BLK_W = 2 * HALF_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic                           decrypt,
  input  logic [BLK_W-1:0]               din,
  output logic [SK_AW-1:0]               sk_raddr,
  input  logic [HALF_W-1:0]              sk_rdata,
  output logic [NUM_TBL-1:0][TBL_AW-1:0] tbl_raddr,
  input  logic [NUM_TBL-1:0][HALF_W-1:0] tbl_rdata,
  output logic                           busy,
  output logic                           done,
  output logic [BLK_W-1:0]               dout
);
  localparam logic [SK_AW-1:0] LAST_IDX   = SK_AW'(NKEYS - 1);
  localparam logic [SK_AW-1:0] ROUND_DONE = SK_AW'(ROUNDS);

  fc_state_e         state_q;
  logic [SK_AW-1:0]  step_q;
  logic              dec_q;
  logic [HALF_W-1:0] l_q, r_q, mixed, f_val;
  logic              busy_q, done_q;
  logic [BLK_W-1:0]  dout_q;

  // left half after subkey mixing: the value whose bytes index the tables
  assign mixed    = l_q ^ sk_rdata;
  assign sk_raddr = dec_q ? (LAST_IDX - step_q) : step_q;

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_addr
    assign tbl_raddr[t] = mixed[HALF_W-1-t*TBL_AW -: TBL_AW];
  end

  fc_round_fn #(.HALF_W(HALF_W)) u_fn (
    .s_word (tbl_rdata),
    .f_out  (f_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      dec_q   <= 1'b0;
      l_q     <= '0;
      r_q     <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      dout_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            l_q     <= din[BLK_W-1:HALF_W];
            r_q     <= din[HALF_W-1:0];
            dec_q   <= decrypt;
            step_q  <= '0;
            busy_q  <= 1'b1;
            state_q <= ST_PRIME;
          end
        end
        ST_PRIME: state_q <= ST_RND_A;
        ST_RND_A: begin
          l_q     <= mixed;
          step_q  <= step_q + 1'b1;
          state_q <= ST_RND_B;
        end
        ST_RND_B: begin
          l_q <= r_q ^ f_val;
          r_q <= l_q;
          if (step_q == ROUND_DONE) begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_WHIT1;
          end else begin
            state_q <= ST_RND_A;
          end
        end
        ST_WHIT1: begin
          // halves are swapped here: l_q holds the final right half
          l_q     <= l_q ^ sk_rdata;
          state_q <= ST_WHIT2;
        end
        ST_WHIT2: begin
          dout_q  <= {r_q ^ sk_rdata, l_q};
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign dout = dout_q;
endmodule

// File: rtl/feistel_block_core.sv
module feistel_block_core
  import fc_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int ROUNDS = 16,
  parameter int TBL_AW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                decrypt,
  input  logic [2*HALF_W-1:0] din,
  output logic                busy,
  output logic                done,
  output logic [2*HALF_W-1:0] dout,
  input  logic                wr_en,
  input  logic [2:0]          wr_sel,
  input  logic [TBL_AW-1:0]   wr_addr,
  input  logic [HALF_W-1:0]   wr_data
);
  localparam int NKEYS     = ROUNDS + 2;
  localparam int SK_AW     = $clog2(NKEYS);
  localparam int TBL_DEPTH = 1 << TBL_AW;
  localparam logic [TBL_AW-1:0] NKEYS_A = TBL_AW'(NKEYS);

  logic                           wr_ok, sk_we;
  logic [SK_AW-1:0]               sk_raddr;
  logic [HALF_W-1:0]              sk_rdata;
  logic [NUM_TBL-1:0][TBL_AW-1:0] tbl_raddr;
  logic [NUM_TBL-1:0][HALF_W-1:0] tbl_rdata;
  logic [NUM_TBL-1:0]             tbl_we;

  assign wr_ok = wr_en && !busy;
  assign sk_we = wr_ok && (wr_sel == SEL_SUBKEY) && (wr_addr < NKEYS_A);

  fc_sync_ram #(.DEPTH(NKEYS), .WIDTH(HALF_W)) u_subkeys (
    .clk   (clk),
    .we    (sk_we),
    .waddr (wr_addr[SK_AW-1:0]),
    .wdata (wr_data),
    .raddr (sk_raddr),
    .rdata (sk_rdata)
  );

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    assign tbl_we[t] = wr_ok && (wr_sel == 3'(t));
    fc_sync_ram #(.DEPTH(TBL_DEPTH), .WIDTH(HALF_W)) u_tbl (
      .clk   (clk),
      .we    (tbl_we[t]),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (tbl_raddr[t]),
      .rdata (tbl_rdata[t])
    );
  end

  fc_round_ctrl #(.HALF_W(HALF_W), .ROUNDS(ROUNDS), .TBL_AW(TBL_AW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .decrypt   (decrypt),
    .din       (din),
    .sk_raddr  (sk_raddr),
    .sk_rdata  (sk_rdata),
    .tbl_raddr (tbl_raddr),
    .tbl_rdata (tbl_rdata),
    .busy      (busy),
    .done      (done),
    .dout      (dout)
  );
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int BLK_W = 64,
  parameter int LAT   = 35,
  localparam int CW   = $clog2(LAT + 2) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [BLK_W-1:0] dout
);
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R5
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(dout)) else $error("dout changed without done"); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("busy still high with done"); // R4
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy) else $error("start not accepted"); // R4
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_cnt == CW'(LAT))) else $error("latency mismatch"); // R4
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $fell(rst) |-> (!busy && !done && dout == '0)) else $error("reset state"); // R1
endmodule

bind feistel_block_core fc_checker #(.BLK_W(2 * HALF_W), .LAT(2 * ROUNDS + 3)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .dout  (dout)
);

// File: tb/feistel_block_core_tb.sv
module feistel_block_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        decrypt = 1'b0;
  logic [63:0] din = '0;
  logic        busy, done;
  logic [63:0] dout;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] mK [18];
  logic [31:0] mT [4][256];

  always #5 clk = ~clk;

  feistel_block_core dut_i (
    .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .din(din),
    .busy(busy), .done(done), .dout(dout),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [31:0] mix_hash(input logic [31:0] n);
    logic [31:0] v;
    v = n * 32'h9E3779B1 + 32'h7F4A7C15;
    v = v ^ (v >> 15);
    v = v * 32'h85EBCA6B;
    v = v ^ (v >> 13);
    return v;
  endfunction

  function automatic logic [31:0] mf(input logic [31:0] x);
    return ((mT[0][x[31:24]] + mT[1][x[23:16]]) ^ mT[2][x[15:8]]) + mT[3][x[7:0]];
  endfunction

  function automatic logic [63:0] model(input logic [63:0] x, input bit dec);
    logic [31:0] l, r, tmp;
    l = x[63:32];
    r = x[31:0];
    for (int i = 0; i < 16; i++) begin
      l   = l ^ mK[dec ? 17 - i : i];
      r   = r ^ mf(l);
      tmp = l; l = r; r = tmp;
    end
    tmp = l; l = r; r = tmp;
    r = r ^ mK[dec ? 1 : 16];
    l = l ^ mK[dec ? 0 : 17];
    return {l, r};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // returns at the negedge after the accepting edge
  task automatic launch(input logic [63:0] x, input bit dec);
    @(negedge clk);
    start = 1'b1; din = x; decrypt = dec;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output logic [63:0] y, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 200);
    y = dout;
  endtask

  task automatic run(input logic [63:0] x, input bit dec, output logic [63:0] y);
    int n;
    launch(x, dec);
    wait_done(y, n);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=%0d expected=<150000 cycles", 150000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] y, y2, x, y_old;
    int n;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && dout == 0, "R1 in reset", {62'd0, busy, done}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && dout == 0, "R1 after release", dout, 64'd0);

    // fill tables and subkeys (R7)
    for (int i = 0; i < 18; i++) begin
      mK[i] = mix_hash(32'(i) + 32'h1000);
      wr(3'd4, 8'(i), mK[i]);
    end
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 256; i++) begin
        mT[t][i] = mix_hash(32'(t * 256 + i));
        wr(3'(t), 8'(i), mT[t][i]);
      end

    // first block: latency, busy, one-cycle done
    x = 64'h0123456789ABCDEF;
    launch(x, 1'b0);
    chk(busy == 1'b1, "R4 busy after start", {63'd0, busy}, 64'd1);
    wait_done(y, n);
    chk(n == 35, "R4 latency", 64'(n), 64'd35);
    chk(busy == 1'b0, "R4 busy low at done", {63'd0, busy}, 64'd0);
    chk(y == model(x, 1'b0), "R2 encrypt fixed block", y, model(x, 1'b0));
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", {63'd0, done}, 64'd0);
    repeat (4) @(negedge clk);
    chk(dout == y, "R5 dout held", dout, y);

    // corner blocks with round trip
    for (int k = 0; k < 2; k++) begin
      x = (k == 0) ? 64'd0 : ~64'd0;
      run(x, 1'b0, y);
      chk(y == model(x, 1'b0), "R2 encrypt corner", y, model(x, 1'b0));
      run(y, 1'b1, y2);
      chk(y2 == x, "R3 round trip corner", y2, x);
    end

    // walking single bit, both directions
    for (int b = 0; b < 64; b++) begin
      x = 64'd1 << b;
      run(x, 1'b0, y);
      chk(y == model(x, 1'b0), "R2 walking bit encrypt", y, model(x, 1'b0));
      run(x, 1'b1, y2);
      chk(y2 == model(x, 1'b1), "R3 walking bit decrypt", y2, model(x, 1'b1));
    end

    // byte sweeps in each position of the left half
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 256; v++) begin
        x = {32'(v) << (8 * p), 32'h5A5A_C3C3};
        run(x, 1'b0, y);
        chk(y == model(x, 1'b0), "R2 byte sweep", y, model(x, 1'b0));
      end

    // R6: start while busy ignored
    x = 64'hFEDC_BA98_7654_3210;
    launch(x, 1'b0);
    repeat (5) @(negedge clk);
    start = 1'b1; din = 64'h1111_2222_3333_4444; decrypt = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(y, n);
    chk(y == model(x, 1'b0), "R6 mid-run start ignored", y, model(x, 1'b0));

    // block whose first lookup in T0 hits entry 5
    x = {8'd5 ^ mK[0][31:24], 24'h00_0000, 32'h0BAD_F00D};
    run(x, 1'b0, y_old);
    chk(y_old == model(x, 1'b0), "R2 targeted block", y_old, model(x, 1'b0));

    // R8: write T0[5] while busy, must be discarded
    launch(x, 1'b0);
    wr(3'd0, 8'd5, 32'hDEAD_BEEF);
    wait_done(y, n);
    run(x, 1'b0, y);
    chk(y == y_old, "R8 busy write discarded", y, y_old);

    // R9: aliasing subkey address discarded
    wr(3'd4, 8'd32, 32'hCAFE_0001);
    wr(3'd4, 8'd18, 32'hCAFE_0002);
    run(x, 1'b0, y);
    chk(y == y_old, "R9 out-of-range subkey write", y, y_old);

    // R7: idle write takes effect
    mT[0][5] = 32'h1357_9BDF;
    wr(3'd0, 8'd5, mT[0][5]);
    run(x, 1'b0, y);
    chk(y == model(x, 1'b0) && y != y_old, "R7 idle table write", y, model(x, 1'b0));
    mK[17] = 32'h2468_ACE0;
    wr(3'd4, 8'd17, mK[17]);
    run(x, 1'b0, y);
    chk(y == model(x, 1'b0), "R7 idle subkey write", y, model(x, 1'b0));
    run(y, 1'b1, y2);
    chk(y2 == x, "R3 round trip after update", y2, x);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule